// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Chain

This block is the digital divider chain of an integer-N frequency synthesizer. A reference counter divides the crystal clock by 64, 80 or 128, chosen by a 2-bit code. A pulse-swallow divider divides the oscillator clock by 32·M + S. M is 10 bits wide and S is 5 bits wide. The block drives a modulus-control line for a dual-modulus 32/33 prescaler and contains a digital model of that prescaler. Each chain produces a one-clock pulse per output period, and a phase detector outside the block compares the two pulses. No fixed division stage sits after the reference counter, so the comparison rate is also the tuning step. With a 4 MHz crystal the step is 62.5, 50 or 31.25 kHz.

Both divided clocks are counted as strobes in one system clock domain: `ref_en` marks a crystal edge and `vco_en` marks an oscillator edge. The settings arrive on parallel inputs. A new setting is taken into the active registers only at the end of an output period, so no period is cut short. If S is not less than the effective M, the setting is flagged as illegal and the divider keeps the last legal setting. A short-word flag models a 14-bit frequency word, in which the top bit of M is treated as zero.

Top module: `swallow_synth_div`

## Requirements
- R1: While `rst_n` is low, `ref_pulse`, `vco_pulse` and `mod33` are 0. Reset leaves the active setting at reference ratio 80, M = DEF_M (64) and S = DEF_S (0).
- R2: The reference code `ref_sel` selects the reference ratio as follows: bit0 = 0 selects 80, whatever bit1 is; `ref_sel` = 2'b01 selects 128; `ref_sel` = 2'b11 selects 64. `ref_pulse` repeats once every ratio `ref_en` strobes.
- R3: `vco_pulse` repeats once every 32·M + S `vco_en` strobes, for any legal M and S, including M = 1023 with S = 31.
- R4: In every output period, `mod33` is 1 for the first S prescaler cycles and 0 for the remaining M − S cycles. With a strobe on every clock, this gives exactly 33·S clocks high per period, and `mod33` equals (S ≠ 0) in the cycle of `vco_pulse`.
- R5: When `short_word` is 1, bit 9 of `m_in` is taken as 0, so the effective M is at most 511.
- R6: `set_err` is 1, in the clock cycle after the inputs change, whenever `s_in` ≥ the effective M. An illegal setting is never loaded, so the previous legal ratio continues.
- R7: A new reference code is loaded only in the clock edge that ends a reference period, and a new M or S only in the edge that ends an oscillator period. A period that is running when the inputs change finishes with its old ratio.
- R8: Each output pulse is one clock wide. It is high in the clock cycle after the edge that sampled the last strobe of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Crystal edge strobe |
| vco_en | input | 1 | Oscillator edge strobe |
| ref_sel | input | 2 | Reference ratio code |
| m_in | input | 10 | Main counter ratio M |
| s_in | input | 5 | Swallow count S |
| short_word | input | 1 | Treat the frequency word as 14-bit (M bit 9 forced to 0) |
| ref_pulse | output | 1 | Divided reference pulse |
| vco_pulse | output | 1 | Divided oscillator pulse |
| mod33 | output | 1 | Prescaler modulus control, 1 = divide by 33 |
| set_err | output | 1 | Requested M/S setting is illegal |

## Verification
Each pulse is registered, so it is high one clock after the edge that counts the last strobe of its period. The bench therefore measures periods from one pulse to the next at falling edges, and the fixed latency cancels out of every measured period. A new setting is checked by first waiting for one boundary, which loads the setting, and then timing the next full period. The truncation check times the period that was already running when the inputs changed. `set_err` is combinational, so it is sampled at the first falling edge after the inputs change.

// File: rtl/swallow_synth_div.sv
module swallow_synth_div #(
  parameter int MW    = 10,
  parameter int SW    = 5,
  parameter int DEF_M = 64,
  parameter int DEF_S = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic          vco_en,
  input  logic [1:0]    ref_sel,
  input  logic [MW-1:0] m_in,
  input  logic [SW-1:0] s_in,
  input  logic          short_word,
  output logic          ref_pulse,
  output logic          vco_pulse,
  output logic          mod33,
  output logic          set_err
);
  localparam int RW = 7;
  localparam logic [SW:0] PLAST32 = {1'b0, {SW{1'b1}}};
  localparam logic [SW:0] PLAST33 = {1'b1, {SW{1'b0}}};

  if (SW < 1 || MW <= SW || DEF_S < 0 || DEF_S >= DEF_M || DEF_M >= (1 << MW)) begin : g_bad_param
    $error("swallow_synth_div: illegal parameter set");
  end

  function automatic logic [RW-1:0] ref_last(input logic [1:0] code);
    if (!code[0])     return 7'd79;
    else if (code[1]) return 7'd63;
    else              return 7'd127;
  endfunction

  logic [RW-1:0] rcnt, rlim;
  logic          ref_end;

  assign ref_end = ref_en && (rcnt == rlim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt      <= '0;
      rlim      <= 7'd79;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= ref_end;
      if (ref_end) begin
        rcnt <= '0;
        rlim <= ref_last(ref_sel);
      end else if (ref_en) begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  logic [MW-1:0] eff_m, m_act, mcnt;
  logic [SW-1:0] s_act;
  logic [SW:0]   pcnt;
  logic          pre_end, vco_end;

  assign eff_m   = short_word ? {1'b0, m_in[MW-2:0]} : m_in;
  assign set_err = {{(MW-SW){1'b0}}, s_in} >= eff_m;
  assign mod33   = mcnt < {{(MW-SW){1'b0}}, s_act};
  assign pre_end = vco_en && (pcnt == (mod33 ? PLAST33 : PLAST32));
  assign vco_end = pre_end && (mcnt == m_act - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt      <= '0;
      mcnt      <= '0;
      m_act     <= MW'(DEF_M);
      s_act     <= SW'(DEF_S);
      vco_pulse <= 1'b0;
    end else begin
      vco_pulse <= vco_end;
      if (pre_end) begin
        pcnt <= '0;
        if (vco_end) begin
          mcnt <= '0;
          if (!set_err) begin
            m_act <= eff_m;
            s_act <= s_in;
          end
        end else begin
          mcnt <= mcnt + 1'b1;
        end
      end else if (vco_en) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swallow_synth_div_chk.sv
module swallow_synth_div_chk #(
  parameter int MW = 10,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_pulse,
  input logic          vco_pulse,
  input logic          mod33,
  input logic          set_err,
  input logic [6:0]    rlim,
  input logic [MW-1:0] m_act,
  input logic [SW-1:0] s_act
);
  AST_REF_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse); // R8
  AST_VCO_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    vco_pulse |=> !vco_pulse); // R8
  AST_REF_LOAD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rlim) |-> ref_pulse); // R7
  AST_DIV_LOAD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(m_act) || !$stable(s_act)) |-> vco_pulse); // R7
  AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    {{(MW-SW){1'b0}}, s_act} < m_act); // R6
  AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_pulse && $past(set_err)) |-> ($stable(m_act) && $stable(s_act))); // R6
  AST_MOD_PERIOD_START: assert property (@(posedge clk) disable iff (!rst_n)
    vco_pulse |-> (mod33 == (s_act != '0))); // R4
endmodule

bind swallow_synth_div swallow_synth_div_chk #(.MW(MW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
  .mod33(mod33), .set_err(set_err), .rlim(rlim), .m_act(m_act), .s_act(s_act)
);

// File: tb/sim_swallow_synth_div.sv
`timescale 1ns/1ps
module sim_swallow_synth_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b1, vco_en = 1'b1;
  logic       ref_half = 1'b0, vco_half = 1'b0;
  logic [1:0] ref_sel = 2'b00;
  logic [9:0] m_in = 10'd64;
  logic [4:0] s_in = 5'd0;
  logic       short_word = 1'b0;
  logic       ref_pulse, vco_pulse, mod33, set_err;
  int         checks = 0, fails = 0;
  localparam int LIM = 40000;

  always #4 clk = ~clk;

  swallow_synth_div u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .vco_en(vco_en), .ref_sel(ref_sel),
    .m_in(m_in), .s_in(s_in), .short_word(short_word), .ref_pulse(ref_pulse),
    .vco_pulse(vco_pulse), .mod33(mod33), .set_err(set_err)
  );

  always @(negedge clk) begin
    ref_en <= ref_half ? ~ref_en : 1'b1;
    vco_en <= vco_half ? ~vco_en : 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int vco_ratio(input int m, input int s, input bit sw);
    return 32 * (sw ? (m % 512) : m) + s;
  endfunction

  task automatic wait_ref();
    int n = 0;
    do begin @(negedge clk); n++; end while (!ref_pulse && n < LIM);
  endtask

  task automatic count_ref(output int p);
    p = 0;
    do begin @(negedge clk); p++; end while (!ref_pulse && p < LIM);
  endtask

  task automatic wait_vco();
    int n = 0;
    do begin @(negedge clk); n++; end while (!vco_pulse && n < LIM);
  endtask

  task automatic count_vco(output int p, output int hi);
    p = 0; hi = 0;
    do begin @(negedge clk); p++; if (mod33) hi++; end while (!vco_pulse && p < LIM);
  endtask

  task automatic set_div(input int m, input int s, input bit sw);
    m_in = 10'(m); s_in = 5'(s); short_word = sw;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 ref_pulse in reset", int'(ref_pulse), 0);
    chk("R1 vco_pulse in reset", int'(vco_pulse), 0);
    chk("R1 mod33 in reset", int'(mod33), 0);
    chk("R6 set_err legal default", int'(set_err), 0);
    rst_n = 1'b1;
    wait_ref();
    begin int p; count_ref(p); chk("R1 reference ratio 80 after reset", p, 80); end
  endtask

  task automatic t_ref_codes();
    int p;
    ref_sel = 2'b11; wait_ref(); count_ref(p); chk("R2 code 11 -> 64", p, 64);
    ref_sel = 2'b01; wait_ref(); count_ref(p); chk("R2 code 01 -> 128", p, 128);
    ref_sel = 2'b00; wait_ref(); count_ref(p); chk("R2 code 00 -> 80", p, 80);
    ref_sel = 2'b10; wait_ref(); count_ref(p); chk("R2 code 10 -> 80 (bit1 ignored)", p, 80);
  endtask

  task automatic t_ref_gapped();
    int p;
    ref_sel = 2'b11; ref_half = 1'b1;
    wait_ref(); count_ref(p); chk("R2 code 11 strobe every other clock", p, 128);
    ref_half = 1'b0;
    wait_ref();
  endtask

  task automatic t_ref_boundary();
    int p;
    wait_ref();
    ref_sel = 2'b01;
    count_ref(p); chk("R7 running reference period keeps 64", p, 64);
    count_ref(p); chk("R7 next reference period uses 128", p, 128);
  endtask

  task automatic t_vco_small();
    int p, hi;
    set_div(5, 3, 0); wait_vco(); count_vco(p, hi);
    chk("R3 M=5 S=3 period", p, vco_ratio(5, 3, 0));
    chk("R4 mod33 high clocks M=5 S=3", hi, 33 * 3);
    set_div(100, 0, 0); wait_vco(); count_vco(p, hi);
    chk("R3 M=100 S=0 period", p, vco_ratio(100, 0, 0));
    chk("R4 mod33 never high with S=0", hi, 0);
    set_div(2, 1, 0); wait_vco(); count_vco(p, hi);
    chk("R3 M=2 S=1 period", p, vco_ratio(2, 1, 0));
    chk("R4 mod33 high clocks M=2 S=1", hi, 33);
  endtask

  task automatic t_vco_gapped();
    int p, hi;
    set_div(5, 3, 0); vco_half = 1'b1;
    wait_vco(); count_vco(p, hi);
    chk("R3 M=5 S=3 strobe every other clock", p, 2 * vco_ratio(5, 3, 0));
    vco_half = 1'b0;
    wait_vco();
  endtask

  task automatic t_illegal();
    int p, hi;
    set_div(5, 3, 0); wait_vco();
    set_div(5, 10, 0); @(negedge clk);
    chk("R6 set_err S>M", int'(set_err), 1);
    wait_vco(); count_vco(p, hi);
    chk("R6 illegal setting keeps previous ratio", p, vco_ratio(5, 3, 0));
    set_div(5, 5, 0); @(negedge clk);
    chk("R6 set_err S=M", int'(set_err), 1);
    set_div(512, 0, 1); @(negedge clk);
    chk("R5 short word M=512 becomes 0 -> error", int'(set_err), 1);
    set_div(512, 0, 0); @(negedge clk);
    chk("R6 M=512 long word legal", int'(set_err), 0);
  endtask

  task automatic t_vco_boundary();
    int p, hi;
    set_div(5, 3, 0); wait_vco(); wait_vco();
    set_div(7, 2, 0);
    count_vco(p, hi); chk("R7 running period keeps M=5 S=3", p, vco_ratio(5, 3, 0));
    count_vco(p, hi); chk("R7 next period uses M=7 S=2", p, vco_ratio(7, 2, 0));
  endtask

  task automatic t_big();
    int p, hi;
    set_div(1023, 31, 0); wait_vco(); count_vco(p, hi);
    chk("R3 M=1023 S=31 period", p, vco_ratio(1023, 31, 0));
    chk("R4 mod33 high clocks S=31", hi, 33 * 31);
  endtask

  task automatic t_short();
    int p, hi;
    set_div(1023, 1, 1); wait_vco(); count_vco(p, hi);
    chk("R5 short word M=1023 -> 511", p, vco_ratio(1023, 1, 1));
  endtask

  initial begin
    t_reset();
    t_ref_codes();
    t_ref_gapped();
    t_ref_boundary();
    t_vco_small();
    t_vco_gapped();
    t_illegal();
    t_vco_boundary();
    t_big();
    t_short();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule